// File: doc/BRIEF.md
# Flash Block Protection Checker

This block decides, in the same cycle, whether an access to a 1 MB flash array may go ahead. Every access carries an address and a kind: data read, instruction fetch, program or erase. The address selects one 2 KB block, and the block's entries in two policy bit sets decide the outcome. One set grants program and erase rights. The other set grants read rights. A block whose whole aligned 16 KB group has both rights removed becomes execute-only. Instruction fetches from such a block still pass, but data reads, programs and erases are refused.

Software maintains the policy through a small write port. Each policy word can only lose permissions. Writing a zero clears a bit, and writing a one changes nothing. Only reset brings a cleared bit back. When a valid access is refused, a sticky violation record keeps the access kind and the address of the first offence. A clear pulse removes the record.

Top module: `flash_guard`

## Requirements
- R1: After reset every policy word of both sets reads back as all ones, every access kind is allowed at every address, and `viol_flag` is 0.
- R2: A cycle with `cfg_we` high replaces the word chosen by `cfg_sel` (0 = program/erase set, 1 = read set) and `cfg_idx` with the bitwise AND of its old value and `cfg_wdata`. `cfg_rdata` always shows the word chosen by `cfg_sel` and `cfg_idx`.
- R3: Writing a one to a cleared policy bit leaves it cleared. Only reset sets it again.
- R4: The block index is `acc_addr[19:11]`. Bits [8:5] of that index pick the policy word and bits [4:0] pick the bit inside it.
- R5: A program access (`acc_type` = 2) or an erase access (`acc_type` = 3) is allowed exactly when the block's program/erase bit is 1.
- R6: A data read (`acc_type` = 0) is allowed exactly when the block's read bit is 1.
- R7: An instruction fetch (`acc_type` = 1) is allowed when the block's read bit is 1. It is also allowed when all eight program/erase bits and all eight read bits of the block's aligned byte (index bits [8:3]) are 0, which is the execute-only case.
- R8: When a byte is only partly cleared, fetches follow the read bit of each block alone.
- R9: A cycle with `acc_valid` high and `acc_allow` low sets `viol_flag` on the next cycle. If the flag was clear, that cycle also captures `acc_type` into `viol_type` and `acc_addr` into `viol_addr`. While the flag stays set, the captured values do not change.
- R10: A `viol_clr` pulse clears the flag on the next cycle. If a refused valid access arrives in the same cycle, the flag stays set and the new access is captured.
- R11: Allowed accesses, and any cycle with `acc_valid` low, leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Policy word write strobe (clear-only) |
| cfg_sel | input | 1 | Set select: 0 program/erase, 1 read |
| cfg_idx | input | 4 | Policy word index |
| cfg_wdata | input | 32 | Write mask; zero bits clear |
| cfg_rdata | output | 32 | Selected policy word |
| acc_valid | input | 1 | Access present this cycle |
| acc_type | input | 2 | 0 read, 1 fetch, 2 program, 3 erase |
| acc_addr | input | 20 | Byte address of the access |
| acc_allow | output | 1 | Access permitted (combinational) |
| viol_clr | input | 1 | Clear the violation record |
| viol_flag | output | 1 | Sticky violation flag |
| viol_type | output | 2 | Kind of the captured violation |
| viol_addr | output | 20 | Address of the captured violation |

## Verification
Directed accesses first check one fully cleared program byte. This shows that program and erase are refused while reads and fetches still pass. Next, a partly cleared read byte is set against a fully cleared one, which separates plain per-block read protection from the execute-only exception for fetches. Accesses at the last block of the last word confirm the index split, and writes of ones to cleared bits check that they do not restore rights. Random traffic then mixes random clear masks, whole-byte clears, all four access kinds, clear pulses and idle cycles. It compares the allow result and the violation record every cycle against a bench model, which covers first-offence capture and a clear that arrives together with a new violation.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_FETCH = 2'd1,
      ACC_PROG  = 2'd2,
      ACC_ERASE = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/flash_guard_regs.sv
module flash_guard_regs #(
   parameter int NUM_REGS = 16,
   parameter int REG_W    = 32,
   localparam int SEL_W   = $clog2(NUM_REGS),
   localparam int NBITS   = NUM_REGS * REG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_set,
   input  logic [SEL_W-1:0] wr_idx,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic [NBITS-1:0] prog_bits,
   output logic [NBITS-1:0] read_bits
);
   logic [REG_W-1:0] prog_q [NUM_REGS];
   logic [REG_W-1:0] read_q [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_idx == SEL_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prog_q[g] <= '1;
            read_q[g] <= '1;
         end else if (hit) begin
            if (wr_set) read_q[g] <= read_q[g] & wr_data;
            else        prog_q[g] <= prog_q[g] & wr_data;
         end
      end

      assign prog_bits[g*REG_W +: REG_W] = prog_q[g];
      assign read_bits[g*REG_W +: REG_W] = read_q[g];
   end

   assign rd_data = wr_set ? read_q[wr_idx] : prog_q[wr_idx];
endmodule

// File: rtl/flash_guard_policy.sv
module flash_guard_policy
   import flash_guard_pkg::*;
#(
   parameter int NBITS = 512,
   parameter int GRP   = 8,
   parameter bit XO_EN = 1'b1,
   localparam int IDX_W = $clog2(NBITS),
   localparam int GRP_W = $clog2(GRP)
) (
   input  logic [NBITS-1:0] prog_bits,
   input  logic [NBITS-1:0] read_bits,
   input  logic [IDX_W-1:0] blk_idx,
   input  acc_kind_e        kind,
   output logic             allow
);
   logic pe_bit, rd_bit, exec_only;

   assign pe_bit = prog_bits[blk_idx];
   assign rd_bit = read_bits[blk_idx];

   if (XO_EN) begin : g_xo
      logic [IDX_W-1:0] base;
      logic [GRP-1:0]   pgrp, rgrp;
      assign base      = {blk_idx[IDX_W-1:GRP_W], {GRP_W{1'b0}}};
      assign pgrp      = prog_bits[base +: GRP];
      assign rgrp      = read_bits[base +: GRP];
      assign exec_only = ~|pgrp & ~|rgrp;
   end else begin : g_no_xo
      assign exec_only = 1'b0;
   end

   always_comb begin
      unique case (kind)
         ACC_READ:  allow = rd_bit;
         ACC_FETCH: allow = rd_bit | exec_only;
         default:   allow = pe_bit;
      endcase
   end
endmodule

// File: rtl/flash_guard_viol.sv
module flash_guard_viol #(
   parameter int ADDR_W = 20,
   parameter int KIND_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_allow,
   input  logic [KIND_W-1:0] acc_kind,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              clr,
   output logic              flag,
   output logic [KIND_W-1:0] kind_q,
   output logic [ADDR_W-1:0] addr_q
);
   logic denied, capture;

   assign denied  = acc_valid && !acc_allow;
   assign capture = denied && (!flag || clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         kind_q <= '0;
         addr_q <= '0;
      end else begin
         if (denied)   flag <= 1'b1;
         else if (clr) flag <= 1'b0;
         if (capture) begin
            kind_q <= acc_kind;
            addr_q <= acc_addr;
         end
      end
   end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import flash_guard_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int BLK_W    = 11,
   parameter int NUM_REGS = 16,
   parameter int REG_W    = 32,
   parameter int GRP      = 8,
   parameter bit XO_EN    = 1'b1,
   localparam int SEL_W   = $clog2(NUM_REGS),
   localparam int NBITS   = NUM_REGS * REG_W,
   localparam int IDX_W   = $clog2(NBITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [SEL_W-1:0]  cfg_idx,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              acc_valid,
   input  logic [1:0]        acc_type,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              acc_allow,
   input  logic              viol_clr,
   output logic              viol_flag,
   output logic [1:0]        viol_type,
   output logic [ADDR_W-1:0] viol_addr
);
   if (ADDR_W - BLK_W != IDX_W) begin : g_bad_map
      $error("flash_guard: address bits above block size must index every policy bit");
   end
   if ((1 << SEL_W) != NUM_REGS) begin : g_bad_regs
      $error("flash_guard: NUM_REGS must be a power of two");
   end
   if ((REG_W % GRP) != 0 || (1 << $clog2(GRP)) != GRP) begin : g_bad_grp
      $error("flash_guard: GRP must be a power of two dividing REG_W");
   end

   logic [NBITS-1:0] prog_bits, read_bits;

   flash_guard_regs #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_set    (cfg_sel),
      .wr_idx    (cfg_idx),
      .wr_data   (cfg_wdata),
      .rd_data   (cfg_rdata),
      .prog_bits (prog_bits),
      .read_bits (read_bits)
   );

   flash_guard_policy #(.NBITS(NBITS), .GRP(GRP), .XO_EN(XO_EN)) policy_i (
      .prog_bits (prog_bits),
      .read_bits (read_bits),
      .blk_idx   (acc_addr[ADDR_W-1:BLK_W]),
      .kind      (acc_kind_e'(acc_type)),
      .allow     (acc_allow)
   );

   flash_guard_viol #(.ADDR_W(ADDR_W), .KIND_W(2)) viol_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_allow (acc_allow),
      .acc_kind  (acc_type),
      .acc_addr  (acc_addr),
      .clr       (viol_clr),
      .flag      (viol_flag),
      .kind_q    (viol_type),
      .addr_q    (viol_addr)
   );
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
   parameter int ADDR_W = 20,
   parameter int BLK_W  = 11,
   parameter int NBITS  = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [1:0]        acc_type,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_allow,
   input logic              viol_clr,
   input logic              viol_flag,
   input logic [1:0]        viol_type,
   input logic [ADDR_W-1:0] viol_addr,
   input logic [NBITS-1:0]  prog_bits,
   input logic [NBITS-1:0]  read_bits
);
   // R3
   prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((prog_bits & ~$past(prog_bits)) == '0));

   // R3
   read_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((read_bits & ~$past(read_bits)) == '0));

   // R5
   prog_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_type[1] && acc_allow) |-> prog_bits[acc_addr[ADDR_W-1:BLK_W]]);

   // R6
   read_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_type == 2'd0 && acc_allow) |-> read_bits[acc_addr[ADDR_W-1:BLK_W]]);

   // R9
   viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_allow) |=> viol_flag);

   // R9
   viol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_flag && !viol_clr) |=> (viol_flag && $stable(viol_type) && $stable(viol_addr)));

   // R10
   viol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_clr && !(acc_valid && !acc_allow)) |=> !viol_flag);

   // R11
   viol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!viol_flag && !(acc_valid && !acc_allow)) |=> !viol_flag);
endmodule

bind flash_guard flash_guard_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .NBITS(NBITS)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_type  (acc_type),
   .acc_addr  (acc_addr),
   .acc_allow (acc_allow),
   .viol_clr  (viol_clr),
   .viol_flag (viol_flag),
   .viol_type (viol_type),
   .viol_addr (viol_addr),
   .prog_bits (prog_bits),
   .read_bits (read_bits)
);

// File: tb/flash_guard_tb.sv
module flash_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_type = '0;
   logic [19:0] acc_addr = '0;
   logic        acc_allow;
   logic        viol_clr = 1'b0, viol_flag;
   logic [1:0]  viol_type;
   logic [19:0] viol_addr;

   int errors = 0, checks = 0;

   logic [31:0] pm [16];
   logic [31:0] rm [16];
   logic        m_flag;
   logic [1:0]  m_type;
   logic [19:0] m_addr;

   always #4 clk = ~clk;

   flash_guard dut_i (.*);

   function automatic logic exp_allow(input logic [1:0] t, input logic [19:0] a);
      logic [8:0] idx;
      logic [3:0] r;
      logic [4:0] b;
      logic pe, re, xo;
      idx = a[19:11];
      r   = idx[8:5];
      b   = idx[4:0];
      pe  = pm[r][b];
      re  = rm[r][b];
      xo  = (pm[r][{b[4:3], 3'b000} +: 8] == 8'h00) && (rm[r][{b[4:3], 3'b000} +: 8] == 8'h00);
      case (t)
         2'd0:    return re;
         2'd1:    return re | xo;
         default: return pe;
      endcase
   endfunction

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 16; i++) begin
         pm[i] = '1;
         rm[i] = '1;
      end
      m_flag = 1'b0;
      m_type = '0;
      m_addr = '0;
   endtask

   // Drive one cycle: check allow before the edge, violation record after it.
   task automatic step(input logic we, input logic sel, input logic [3:0] idx, input logic [31:0] wd,
                       input logic v, input logic [1:0] t, input logic [19:0] a, input logic clr,
                       input string req);
      logic ea, den;
      cfg_we = we; cfg_sel = sel; cfg_idx = idx; cfg_wdata = wd;
      acc_valid = v; acc_type = t; acc_addr = a; viol_clr = clr;
      #1;
      ea = exp_allow(t, a);
      chk(acc_allow === ea, req, {31'b0, acc_allow}, {31'b0, ea});
      @(posedge clk);
      den = v && !ea;
      if (den && (!m_flag || clr)) begin
         m_type = t;
         m_addr = a;
      end
      if (den)      m_flag = 1'b1;
      else if (clr) m_flag = 1'b0;
      if (we) begin
         if (sel) rm[idx] = rm[idx] & wd;
         else     pm[idx] = pm[idx] & wd;
      end
      @(negedge clk);
      #1;
      chk(viol_flag === m_flag, {req, " flag"}, {31'b0, viol_flag}, {31'b0, m_flag});
      if (m_flag) begin
         chk(viol_type === m_type, {req, " type"}, {30'b0, viol_type}, {30'b0, m_type});
         chk(viol_addr === m_addr, {req, " addr"}, {12'b0, viol_addr}, {12'b0, m_addr});
      end
      cfg_we = 1'b0; acc_valid = 1'b0; viol_clr = 1'b0;
   endtask

   task automatic readback(input logic sel, input logic [3:0] idx, input string req);
      logic [31:0] e;
      cfg_we = 1'b0; cfg_sel = sel; cfg_idx = idx;
      #1;
      e = sel ? rm[idx] : pm[idx];
      chk(cfg_rdata === e, req, cfg_rdata, e);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      do_reset();

      // R1: reset state
      for (int i = 0; i < 16; i++) begin
         readback(1'b0, 4'(i), "R1 prog reset");
         readback(1'b1, 4'(i), "R1 read reset");
      end
      chk(viol_flag === 1'b0, "R1 flag reset", {31'b0, viol_flag}, 32'd0);
      for (int k = 0; k < 4; k++) step(0, 0, 0, '1, 1, 2'(k), 20'hABC00, 0, "R1 all allowed");

      // R2, R5: clear first program byte of word 0
      step(1, 0, 0, 32'hFFFF_FF00, 0, 0, 0, 0, "R2 write");
      readback(1'b0, 4'd0, "R2 readback");
      step(0, 0, 0, '1, 1, 2'd2, 20'h00000, 0, "R5 program denied");
      step(0, 0, 0, '1, 1, 2'd0, 20'h00010, 0, "R6 read still allowed");
      step(0, 0, 0, '1, 1, 2'd1, 20'h03FFC, 0, "R7 fetch still allowed");
      step(0, 0, 0, '1, 1, 2'd2, 20'h04000, 0, "R5 next byte allowed");
      // R9: second offence keeps first record
      step(0, 0, 0, '1, 1, 2'd3, 20'h00800, 0, "R9 hold first");
      // R10: clear
      step(0, 0, 0, '1, 0, 0, 0, 1, "R10 clear");

      // R8: partly cleared read byte
      step(1, 1, 0, 32'hFFFF_FFF0, 0, 0, 0, 0, "R2 read write");
      step(0, 0, 0, '1, 1, 2'd1, 20'h00800, 0, "R8 partial fetch denied");
      step(0, 0, 0, '1, 1, 2'd1, 20'h02800, 0, "R8 partial fetch allowed");
      step(0, 0, 0, '1, 1, 2'd0, 20'h00000, 1, "R10 clear with new violation");
      step(0, 0, 0, '1, 0, 0, 0, 1, "R10 clear");
      // R7: whole byte cleared in both sets -> execute-only
      step(1, 1, 0, 32'hFFFF_FF00, 0, 0, 0, 0, "R2 read write");
      step(0, 0, 0, '1, 1, 2'd1, 20'h01000, 0, "R7 xo fetch allowed");
      step(0, 0, 0, '1, 1, 2'd0, 20'h01000, 0, "R7 xo read denied");
      step(0, 0, 0, '1, 1, 2'd3, 20'h01000, 0, "R7 xo erase denied");
      step(0, 0, 0, '1, 0, 0, 0, 1, "R10 clear");

      // R3: ones do not restore
      step(1, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, "R3 write ones");
      readback(1'b0, 4'd0, "R3 still cleared");
      step(0, 0, 0, '1, 1, 2'd2, 20'h00000, 0, "R3 program still denied");
      step(0, 0, 0, '1, 0, 0, 0, 1, "R10 clear");

      // R4: last word, last bit
      step(1, 0, 15, 32'h7FFF_FFFF, 0, 0, 0, 0, "R4 write");
      step(0, 0, 0, '1, 1, 2'd2, 20'hFF800, 0, "R4 top block denied");
      step(0, 0, 0, '1, 0, 0, 0, 1, "R10 clear");
      step(0, 0, 0, '1, 1, 2'd2, 20'hFF000, 0, "R4 neighbour allowed");
      // R11: invalid denied access leaves flag clear
      step(0, 0, 0, '1, 0, 2'd2, 20'hFF800, 0, "R11 idle no flag");

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         logic we, sel, clr, v;
         logic [3:0] idx;
         logic [31:0] wd;
         logic [19:0] a;
         we  = ($urandom % 10) == 0;
         sel = 1'($urandom);
         idx = 4'($urandom);
         if ($urandom % 2) wd = ~(32'hFF << (8 * ($urandom % 4)));
         else              wd = $urandom | $urandom | $urandom;
         v   = ($urandom % 4) != 0;
         clr = ($urandom % 5) == 0;
         a   = 20'($urandom);
         step(we, sel, idx, wd, v, 2'($urandom), a, clr, "R7 R9 R10 R11 random");
      end
      for (int i = 0; i < 16; i++) readback(1'b0, 4'(i), "R2 random prog word");

      // R3: only reset restores
      do_reset();
      for (int i = 0; i < 16; i++) readback(1'b1, 4'(i), "R3 reset restores");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule